// File: doc/BRIEF.md
# Register base-bound permission sidecar

This block keeps a small permission cache next to every address register and one more next to the program counter. Each entry, called a sidecar, holds a valid flag, an inclusive address range written as a base and a bound, a two-bit permission and a translation offset. The offset is only stored and presented; applying it to an address is left to other logic. A check names a register and gives an effective address and an access kind. If that register's sidecar is valid and the address lies in its range, the sidecar alone settles the check in the same cycle: the access is granted, or it faults if the permission forbids it. No lookaside-buffer lookup happens in either case.

In every other case the block raises a lookup request toward the lookaside buffer. The request carries the sidecar index, the address and the access kind. The buffer later answers through the refill port, and the refill writes the returned region into the named sidecar. A region is any pair of base and bound, so its size need not be a power of two. Writing a new value into an address register drops that register's sidecar. A change of protection domain drops all sidecars at once.

Top module: `sidecar_perm_cache`

## Requirements
- R1: After reset every sidecar is invalid, so every check raises a lookup request and neither grants nor faults.
- R2: A check grants (`chk_ok`=1) in the same cycle, with no lookup request, when the selected sidecar is valid, base <= address <= bound with both ends inclusive, and the permission allows the access kind.
- R3: The permission codes are 0 = none, 1 = read-only, 2 = read-write and 3 = execute-read. A load (kind 0) is allowed by codes 1, 2 and 3. A store (kind 1) is allowed by code 2 only. A fetch is allowed by code 3 only.
- R4: An in-range check on a valid sidecar whose permission forbids the access faults (`chk_fault`=1) in the same cycle and raises no lookup request.
- R5: A check whose selected sidecar is invalid, or whose address is outside the range, raises `lkp_req` in the same cycle. The request presents `lkp_idx` = selected sidecar, `lkp_addr` = address and `lkp_kind` = access kind.
- R6: Kinds 2 and 3 (kind bit 1 set) are fetches and select the program-counter sidecar, index NREG, ignoring `chk_reg`. Kinds 0 and 1 select sidecar `chk_reg`.
- R7: A refill with `fill_idx` <= NREG writes base, bound, permission and offset into that sidecar and marks it valid from the next cycle. A refill with `fill_idx` > NREG changes nothing.
- R8: `wr_en` invalidates sidecar `wr_idx` (an address register, never the program-counter sidecar) from the next cycle. It wins over a same-cycle refill to the same sidecar.
- R9: `domain_chg` invalidates all sidecars from the next cycle and discards a same-cycle refill.
- R10: On a grant `chk_off` shows the stored offset of the selected sidecar. Otherwise it is zero.
- R11: Regions of any size, including sizes that are not a power of two and single-address regions, hit exactly on their inclusive range.
- R12: With `chk_valid` low, `chk_ok`, `chk_fault` and `lkp_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| domain_chg | input | 1 | Protection domain changed; drop all sidecars |
| wr_en | input | 1 | An address register is being written |
| wr_idx | input | RW | Index of the register being written |
| chk_valid | input | 1 | A check is presented this cycle |
| chk_reg | input | RW | Address register used by a load or store |
| chk_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| chk_addr | input | AW | Effective address to check |
| chk_ok | output | 1 | Access granted by the sidecar |
| chk_fault | output | 1 | Access refused by the sidecar |
| chk_off | output | OFFW | Stored offset on a grant, else zero |
| lkp_req | output | 1 | Sidecar miss; lookup requested |
| lkp_idx | output | SW | Sidecar to refill |
| lkp_addr | output | AW | Address to look up |
| lkp_kind | output | 2 | Access kind of the missed check |
| fill_valid | input | 1 | Refill from the lookaside buffer |
| fill_idx | input | SW | Sidecar to write |
| fill_base | input | AW | Region base, inclusive |
| fill_bound | input | AW | Region bound, inclusive |
| fill_perm | input | 2 | Region permission code |
| fill_off | input | OFFW | Region translation offset |

## Verification
The bench builds the block with NREG = 4, AW = 16 and OFFW = 8. With those values a 3-bit sidecar index can name the out-of-range refill slots 5 to 7, and random addresses placed close to stored bases and bounds often land exactly on range edges. Random refills, register writes and domain changes run alongside checks, and the results are compared with a model of the sidecar state kept in the bench. Directed cases cover a non-power-of-two region, a one-address region, fetch through the program-counter sidecar, and the cases where invalidation or a domain change meets a refill in the same cycle.

// File: rtl/sidecar_perm_cache.sv
module sidecar_perm_cache #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int OFFW = 32,
  localparam int NSC = NREG + 1,
  localparam int SW  = $clog2(NSC),
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            domain_chg,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_idx,
  input  logic            chk_valid,
  input  logic [RW-1:0]   chk_reg,
  input  logic [1:0]      chk_kind,
  input  logic [AW-1:0]   chk_addr,
  output logic            chk_ok,
  output logic            chk_fault,
  output logic [OFFW-1:0] chk_off,
  output logic            lkp_req,
  output logic [SW-1:0]   lkp_idx,
  output logic [AW-1:0]   lkp_addr,
  output logic [1:0]      lkp_kind,
  input  logic            fill_valid,
  input  logic [SW-1:0]   fill_idx,
  input  logic [AW-1:0]   fill_base,
  input  logic [AW-1:0]   fill_bound,
  input  logic [1:0]      fill_perm,
  input  logic [OFFW-1:0] fill_off
);

  logic [NSC-1:0]  vld;
  logic [AW-1:0]   base_q [NSC];
  logic [AW-1:0]   bnd_q  [NSC];
  logic [1:0]      perm_q [NSC];
  logic [OFFW-1:0] off_q  [NSC];

  logic [SW-1:0] sel;
  logic          in_rng, allow, covered;
  logic          fill_ok;

  assign sel     = chk_kind[1] ? SW'(NREG) : SW'(chk_reg);
  assign in_rng  = (base_q[sel] <= chk_addr) && (chk_addr <= bnd_q[sel]);
  assign covered = vld[sel] && in_rng;
  assign fill_ok = fill_valid && (fill_idx <= SW'(NREG));

  always_comb begin
    unique case (chk_kind)
      2'd0:    allow = perm_q[sel] != 2'd0;
      2'd1:    allow = perm_q[sel] == 2'd2;
      default: allow = perm_q[sel] == 2'd3;
    endcase
  end

  assign chk_ok    = chk_valid && covered && allow;
  assign chk_fault = chk_valid && covered && !allow;
  assign chk_off   = chk_ok ? off_q[sel] : '0;
  assign lkp_req   = chk_valid && !covered;
  assign lkp_idx   = sel;
  assign lkp_addr  = chk_addr;
  assign lkp_kind  = chk_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (domain_chg) begin
      vld <= '0;
    end else begin
      if (fill_ok) vld[fill_idx] <= 1'b1;
      if (wr_en)   vld[wr_idx]   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok && !domain_chg) begin
      base_q[fill_idx] <= fill_base;
      bnd_q[fill_idx]  <= fill_bound;
      perm_q[fill_idx] <= fill_perm;
      off_q[fill_idx]  <= fill_off;
    end
  end

endmodule

module sidecar_perm_cache_chk #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int OFFW = 32,
  localparam int NSC = NREG + 1,
  localparam int SW  = $clog2(NSC),
  localparam int RW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            domain_chg,
  input logic            wr_en,
  input logic [RW-1:0]   wr_idx,
  input logic            chk_valid,
  input logic [RW-1:0]   chk_reg,
  input logic [1:0]      chk_kind,
  input logic [AW-1:0]   chk_addr,
  input logic            chk_ok,
  input logic            chk_fault,
  input logic [OFFW-1:0] chk_off,
  input logic            lkp_req,
  input logic [SW-1:0]   lkp_idx,
  input logic [AW-1:0]   lkp_addr,
  input logic [1:0]      lkp_kind,
  input logic            fill_valid,
  input logic [SW-1:0]   fill_idx,
  input logic [AW-1:0]   fill_base,
  input logic [AW-1:0]   fill_bound,
  input logic [1:0]      fill_perm,
  input logic [OFFW-1:0] fill_off
);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !(chk_ok || chk_fault || lkp_req));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $countones({chk_ok, chk_fault, lkp_req}) == 1);

  a_r9_domain_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(domain_chg) && chk_valid) |-> lkp_req);

  a_r8_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(domain_chg) && chk_valid && !chk_kind[1] &&
     chk_reg == $past(wr_idx)) |-> lkp_req);

  a_r7_pc_refill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && !domain_chg && fill_idx == SW'(NREG) &&
           fill_perm == 2'd3 && fill_base <= fill_bound) &&
     chk_valid && chk_kind[1] && chk_addr == $past(fill_base)) |-> chk_ok);

  a_r10_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_ok |-> chk_off == '0);

endmodule

bind sidecar_perm_cache sidecar_perm_cache_chk #(.NREG(NREG), .AW(AW), .OFFW(OFFW)) u_chk (.*);

// File: tb/sidecar_perm_cache_tb.sv
module sidecar_perm_cache_tb;
  localparam int NREG = 4;
  localparam int AW   = 16;
  localparam int OFFW = 8;
  localparam int NSC  = NREG + 1;
  localparam int SW   = $clog2(NSC);
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0, rst_n = 1'b0;
  logic domain_chg = 0, wr_en = 0, chk_valid = 0, fill_valid = 0;
  logic [RW-1:0] wr_idx = '0, chk_reg = '0;
  logic [1:0] chk_kind = '0, fill_perm = '0, lkp_kind;
  logic [AW-1:0] chk_addr = '0, fill_base = '0, fill_bound = '0, lkp_addr;
  logic [OFFW-1:0] fill_off = '0, chk_off;
  logic [SW-1:0] fill_idx = '0, lkp_idx;
  logic chk_ok, chk_fault, lkp_req;

  always #4 clk = ~clk;

  sidecar_perm_cache #(.NREG(NREG), .AW(AW), .OFFW(OFFW)) u_dut (.*);

  bit              m_v   [NSC];
  logic [AW-1:0]   m_b   [NSC];
  logic [AW-1:0]   m_e   [NSC];
  logic [1:0]      m_p   [NSC];
  logic [OFFW-1:0] m_o   [NSC];

  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic bit allowed(input logic [1:0] kind, input logic [1:0] perm);
    if (kind == 2'd0) return perm != 2'd0;
    if (kind == 2'd1) return perm == 2'd2;
    return perm == 2'd3;
  endfunction

  function automatic int pick(input logic [1:0] kind, input logic [RW-1:0] r);
    return kind[1] ? NREG : int'(r);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic verify(input string req);
    int s;
    bit cov, ok, flt, rq;
    s   = pick(chk_kind, chk_reg);
    cov = m_v[s] && m_b[s] <= chk_addr && chk_addr <= m_e[s];
    ok  = chk_valid && cov && allowed(chk_kind, m_p[s]);
    flt = chk_valid && cov && !allowed(chk_kind, m_p[s]);
    rq  = chk_valid && !cov;
    check(req, {chk_ok, chk_fault, lkp_req}, {ok, flt, rq});
    check({req, " off R10"}, chk_off, ok ? m_o[s] : '0);
    if (rq) check({req, " lkp R5"}, {lkp_idx, lkp_addr, lkp_kind},
                  {SW'(s), chk_addr, chk_kind});
  endtask

  task automatic commit;
    if (domain_chg) begin
      for (int i = 0; i < NSC; i++) m_v[i] = 0;
    end else begin
      if (fill_valid && fill_idx <= SW'(NREG)) begin
        m_v[fill_idx] = 1; m_b[fill_idx] = fill_base; m_e[fill_idx] = fill_bound;
        m_p[fill_idx] = fill_perm; m_o[fill_idx] = fill_off;
      end
      if (wr_en) m_v[wr_idx] = 0;
    end
  endtask

  task automatic step(input string req);
    #2 verify(req);
    commit();
    @(posedge clk); @(negedge clk);
    domain_chg = 0; wr_en = 0; fill_valid = 0; chk_valid = 0;
  endtask

  task automatic fill(input int idx, input int b, input int e, input int p, input int o);
    fill_valid = 1; fill_idx = SW'(idx); fill_base = AW'(b); fill_bound = AW'(e);
    fill_perm = 2'(p); fill_off = OFFW'(o);
  endtask

  task automatic chk(input int r, input int k, input int a);
    chk_valid = 1; chk_reg = RW'(r); chk_kind = 2'(k); chk_addr = AW'(a);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd91));
    for (int i = 0; i < NSC; i++) begin
      m_v[i] = 0; m_b[i] = '0; m_e[i] = '0; m_p[i] = '0; m_o[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      chk(i, 0, 16'h0100); step("R1 reset miss");
    end
    chk(0, 2, 0); step("R1 reset pc miss");
    step("R12 idle");

    fill(1, 'h103, 'h208, 1, 'h5A); step("R7 fill");
    chk(1, 0, 'h103); step("R11 base edge hit");
    chk(1, 0, 'h208); step("R11 bound edge hit");
    chk(1, 0, 'h102); step("R11 below base miss");
    chk(1, 0, 'h209); step("R11 above bound miss");
    chk(1, 1, 'h150); step("R4 store on read-only faults");
    chk(1, 3, 'h150); step("R6 fetch ignores chk_reg");
    chk(2, 0, 'h150); step("R2 other register misses");

    fill(4, 'h40, 'h7F, 3, 'h11); step("R7 pc fill");
    chk(0, 2, 'h40); step("R6 pc fetch hit");
    chk(3, 3, 'h7F); step("R3 pc fetch exec-read");
    chk(0, 0, 'h60); step("R3 load misses in reg0");

    fill(0, 'h300, 'h300, 2, 'h22); step("R11 single address");
    chk(0, 1, 'h300); step("R3 store on read-write");
    chk(0, 2, 'h300); step("R6 pc unaffected by reg fill");
    fill(0, 'h300, 'h300, 0, 0); step("R7 perm none");
    chk(0, 0, 'h300); step("R3 load on none faults");

    fill(7, 'h0, 'hFFFF, 2, 1); step("R7 out-of-range idx ignored");
    chk(3, 0, 'h10); step("R7 idx 7 no effect");

    fill(2, 'h10, 'h20, 2, 3); wr_en = 1; wr_idx = 2; step("R8 write wins over fill");
    chk(2, 0, 'h15); step("R8 invalidated");
    fill(2, 'h10, 'h20, 2, 3); step("R7 refill");
    wr_en = 1; wr_idx = 2; step("R8 write");
    chk(2, 0, 'h15); step("R8 write drops");
    chk(1, 0, 'h150); step("R8 neighbour kept");

    fill(3, 'h500, 'h5FF, 3, 9); domain_chg = 1; step("R9 domain drops fill");
    chk(3, 0, 'h500); step("R9 fill discarded");
    chk(1, 0, 'h150); step("R9 all dropped");
    chk(0, 2, 'h40); step("R9 pc dropped");

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 15);
      if (r < 6) begin
        int b = $urandom_range(0, 'hFE00);
        fill($urandom_range(0, 7), b, b + $urandom_range(0, 300),
             $urandom_range(0, 3), $urandom_range(0, 255));
      end
      if (r == 6) begin wr_en = 1; wr_idx = RW'($urandom_range(0, NREG - 1)); end
      if (r == 7 && $urandom_range(0, 3) == 0) domain_chg = 1;
      if ($urandom_range(0, 3) != 0) begin
        int k = $urandom_range(0, 3);
        int rg = $urandom_range(0, NREG - 1);
        int s = pick(2'(k), RW'(rg));
        int a = m_b[s] + $urandom_range(0, 320) - 10;
        chk(rg, k, a);
      end
      step("R2 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule